// File: doc/BRIEF.md
# Rectangle Blit Address Generator

This block walks a rectangle of pixels in a linear frame buffer and produces, for each pixel, a source byte address and a destination byte address. Software sets up the two start addresses, a row pitch for each map, the rectangle size, a pixel format and the traversal options on the configuration inputs. It then pulses `start`. The block captures the whole configuration in that cycle and keeps it until the walk ends, so the inputs may change while it runs.

The address pairs leave on a valid/ready stream at one pair per cycle. They are ordered row by row, and within each row pixel by pixel. The start addresses name the first pixel visited. Each axis can run backwards, so an overlapping copy can be ordered safely: with the X bit set the start address is the rightmost pixel of a row, and with the Y bit set it is the bottom row. A draw mode can drop the very first or the very last position of the walk from the stream. The walk still steps over a dropped position.

`busy` is high from the cycle after an accepted start until the walk has passed its final position. Raster-op mixing, colour depth conversion and the memory accesses themselves belong to other blocks.

Top module: `blit_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `out_valid` are 0 until a start is accepted.
- R2: A `start` seen while `busy` is 0 captures every configuration input and raises `busy` in the next cycle. The first position is then presented on `src_addr`/`dst_addr`, equal to the two start addresses.
- R3: `width_m1` and `height_m1` hold the pixel count minus one. A walk therefore visits (width_m1+1)×(height_m1+1) positions, row by row.
- R4: Within a row, each step changes the address by the bytes per pixel given by `pix_fmt`: 0 gives 1 byte, 1 gives 2, 2 gives 3 and 3 gives 4. The step is added when `rev_x`=0 and subtracted when `rev_x`=1. Addresses wrap modulo 2^ADDR_W.
- R5: Moving to the next row sets the address to the previous row's first address plus the map pitch when `rev_y`=0, or minus the pitch when `rev_y`=1.
- R6: While `out_valid` is 1 and `out_ready` is 0, the pair on the outputs and `out_valid` hold unchanged into the next cycle.
- R7: `draw_mode` encodings: 0 and 3 emit every position. 1 does not emit the first position of the walk. 2 does not emit the last position. A position that is not emitted still costs one cycle, and the walk moves past it.
- R8: `busy` falls in the cycle after the final position is passed, which is either the acceptance of the final pair or the cycle spent on a suppressed final position. Busy lasts exactly positions + stall cycles.
- R9: A `start` while `busy` is 1 is ignored. Configuration inputs that change during a walk do not alter its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, honoured only when idle |
| src_base | input | ADDR_W | Source address of the first pixel visited |
| dst_base | input | ADDR_W | Destination address of the first pixel visited |
| src_pitch | input | PITCH_W | Source row pitch in bytes |
| dst_pitch | input | PITCH_W | Destination row pitch in bytes |
| width_m1 | input | DIM_W | Pixels per row minus one |
| height_m1 | input | DIM_W | Rows minus one |
| pix_fmt | input | 2 | Bytes per pixel minus one |
| rev_x | input | 1 | 1: walk each row right to left |
| rev_y | input | 1 | 1: walk rows bottom up |
| draw_mode | input | 2 | 0/3 all, 1 drop first, 2 drop last |
| busy | output | 1 | Walk in progress |
| out_valid | output | 1 | Address pair present |
| out_ready | input | 1 | Consumer accepts the pair |
| src_addr | output | ADDR_W | Source byte address |
| dst_addr | output | ADDR_W | Destination byte address |

## Verification
The assertions check on every cycle that a stalled pair holds steady, that no pair appears while idle, and that an idle start raises busy. They also check that busy only falls after a cycle in which the walk could advance. The exact address sequence needs the scenarios to show it: per-pixel stepping in each format, row stepping in either direction, wrap-around, and which position the draw modes drop. The same holds for the busy length, for a start that arrives mid-walk, and for a reset in the middle of a walk.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [1:0] {
    DM_ALL       = 2'd0,
    DM_DROP_HEAD = 2'd1,
    DM_DROP_TAIL = 2'd2,
    DM_ALL_ALT   = 2'd3
  } draw_mode_e;

  // Bytes per pixel from the 2-bit format code.
  function automatic logic [2:0] fmt_bytes(input logic [1:0] fmt);
    return {1'b0, fmt} + 3'd1;
  endfunction

endpackage

// File: rtl/blit_pos_ctr.sv
module blit_pos_ctr #(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [DIM_W-1:0] width_m1,
  input  logic [DIM_W-1:0] height_m1,
  output logic             x_end,
  output logic             y_end,
  output logic             at_head
);

  logic [DIM_W-1:0] w_q, h_q, x_q, y_q;
  logic [DIM_W-1:0] x_d, y_d;
  logic             cnt_en;

  assign x_end   = (x_q == w_q);
  assign y_end   = (y_q == h_q);
  assign at_head = (x_q == '0) && (y_q == '0);
  assign cnt_en  = load | adv;

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (load) begin
      x_d = '0;
      y_d = '0;
    end else if (adv) begin
      if (x_end) begin
        x_d = '0;
        y_d = y_q + 1'b1;
      end else begin
        x_d = x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= '0;
      h_q <= '0;
    end else if (load) begin
      w_q <= width_m1;
      h_q <= height_m1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (cnt_en) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

endmodule

// File: rtl/blit_addr_walk.sv
module blit_addr_walk #(
  parameter int ADDR_W  = 22,
  parameter int PITCH_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ADDR_W-1:0]  base_in,
  input  logic [PITCH_W-1:0] pitch_in,
  input  logic [2:0]         bpp_in,
  input  logic               rev_x_in,
  input  logic               rev_y_in,
  input  logic               step_col,
  input  logic               step_row,
  output logic [ADDR_W-1:0]  addr
);

  logic [ADDR_W-1:0]  row_q, cur_q, row_d, cur_d;
  logic [PITCH_W-1:0] pitch_q;
  logic [2:0]         bpp_q;
  logic               rx_q, ry_q;
  logic [ADDR_W-1:0]  col_delta, row_delta, next_row;
  logic               walk_en;

  assign col_delta = ADDR_W'(bpp_q);
  assign row_delta = ADDR_W'(pitch_q);
  assign next_row  = ry_q ? (row_q - row_delta) : (row_q + row_delta);
  assign walk_en   = load | step_col | step_row;
  assign addr      = cur_q;

  always_comb begin
    row_d = row_q;
    cur_d = cur_q;
    if (load) begin
      row_d = base_in;
      cur_d = base_in;
    end else if (step_row) begin
      row_d = next_row;
      cur_d = next_row;
    end else if (step_col) begin
      cur_d = rx_q ? (cur_q - col_delta) : (cur_q + col_delta);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pitch_q <= '0;
      bpp_q   <= 3'd1;
      rx_q    <= 1'b0;
      ry_q    <= 1'b0;
    end else if (load) begin
      pitch_q <= pitch_in;
      bpp_q   <= bpp_in;
      rx_q    <= rev_x_in;
      ry_q    <= rev_y_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      cur_q <= '0;
    end else if (walk_en) begin
      row_q <= row_d;
      cur_q <= cur_d;
    end
  end

endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] mode_in,
  input  logic       x_end,
  input  logic       y_end,
  input  logic       at_head,
  input  logic       out_ready,
  output logic       busy,
  output logic       out_valid,
  output logic       load,
  output logic       adv_pos,
  output logic       step_col,
  output logic       step_row
);

  logic       busy_q, busy_d;
  draw_mode_e mode_q;
  logic       final_pos, suppress, adv;

  assign final_pos = x_end & y_end;
  assign load      = start & ~busy_q;

  always_comb begin
    suppress = 1'b0;
    if (busy_q) begin
      unique case (mode_q)
        DM_DROP_HEAD: suppress = at_head;
        DM_DROP_TAIL: suppress = final_pos;
        default:      suppress = 1'b0;
      endcase
    end
  end

  assign out_valid = busy_q & ~suppress;
  assign adv       = busy_q & (suppress | out_ready);
  assign adv_pos   = adv & ~final_pos;
  assign step_row  = adv_pos & x_end;
  assign step_col  = adv_pos & ~x_end;
  assign busy      = busy_q;

  always_comb begin
    busy_d = busy_q;
    if (load)                  busy_d = 1'b1;
    else if (adv && final_pos) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= DM_ALL;
    else if (load) mode_q <= draw_mode_e'(mode_in);
  end

endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen
  import blit_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int PITCH_W = 12,
  parameter int DIM_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  src_base,
  input  logic [ADDR_W-1:0]  dst_base,
  input  logic [PITCH_W-1:0] src_pitch,
  input  logic [PITCH_W-1:0] dst_pitch,
  input  logic [DIM_W-1:0]   width_m1,
  input  logic [DIM_W-1:0]   height_m1,
  input  logic [1:0]         pix_fmt,
  input  logic               rev_x,
  input  logic               rev_y,
  input  logic [1:0]         draw_mode,
  output logic               busy,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [ADDR_W-1:0]  dst_addr
);

  localparam int NMAPS = 2;

  logic                          load, adv_pos, step_col, step_row;
  logic                          x_end, y_end, at_head;
  logic [2:0]                    bpp;
  logic [NMAPS-1:0][ADDR_W-1:0]  map_base;
  logic [NMAPS-1:0][PITCH_W-1:0] map_pitch;
  logic [NMAPS-1:0][ADDR_W-1:0]  map_addr;

  assign bpp          = fmt_bytes(pix_fmt);
  assign map_base[0]  = src_base;
  assign map_base[1]  = dst_base;
  assign map_pitch[0] = src_pitch;
  assign map_pitch[1] = dst_pitch;
  assign src_addr     = map_addr[0];
  assign dst_addr     = map_addr[1];

  blit_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_in   (draw_mode),
    .x_end     (x_end),
    .y_end     (y_end),
    .at_head   (at_head),
    .out_ready (out_ready),
    .busy      (busy),
    .out_valid (out_valid),
    .load      (load),
    .adv_pos   (adv_pos),
    .step_col  (step_col),
    .step_row  (step_row)
  );

  blit_pos_ctr #(.DIM_W(DIM_W)) pos_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .adv       (adv_pos),
    .width_m1  (width_m1),
    .height_m1 (height_m1),
    .x_end     (x_end),
    .y_end     (y_end),
    .at_head   (at_head)
  );

  for (genvar m = 0; m < NMAPS; m++) begin : g_map
    blit_addr_walk #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) walk_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .base_in  (map_base[m]),
      .pitch_in (map_pitch[m]),
      .bpp_in   (bpp),
      .rev_x_in (rev_x),
      .rev_y_in (rev_y),
      .step_col (step_col),
      .step_row (step_row),
      .addr     (map_addr[m])
    );
  end

endmodule

// File: rtl/blit_addr_gen_chk.sv
module blit_addr_gen_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r2_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(src_addr) && $stable(dst_addr)));

  a_r8_fall_after_move: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_ready || !out_valid));

endmodule

bind blit_addr_gen blit_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .src_addr  (src_addr),
  .dst_addr  (dst_addr)
);

// File: tb/blit_addr_gen_tb_top.sv
module blit_addr_gen_tb_top;

  typedef struct packed {
    logic [21:0] src;
    logic [21:0] dst;
    logic [11:0] sp;
    logic [11:0] dp;
    logic [11:0] w;
    logic [11:0] h;
    logic [1:0]  fmt;
    logic        xn;
    logic        yn;
    logic [1:0]  mode;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{22'h000100, 22'h001000, 12'd64,  12'd128, 12'd3, 12'd2, 2'd0, 1'b0, 1'b0, 2'd0},
    '{22'h000200, 22'h002040, 12'd32,  12'd48,  12'd2, 12'd1, 2'd1, 1'b1, 1'b0, 2'd0},
    '{22'h010000, 22'h020000, 12'd100, 12'd200, 12'd1, 12'd2, 2'd2, 1'b0, 1'b1, 2'd0},
    '{22'h004000, 22'h008000, 12'd16,  12'd40,  12'd2, 12'd2, 2'd3, 1'b1, 1'b1, 2'd0},
    '{22'h000010, 22'h000020, 12'd8,   12'd8,   12'd3, 12'd0, 2'd0, 1'b0, 1'b0, 2'd1},
    '{22'h000400, 22'h000800, 12'd20,  12'd24,  12'd0, 12'd3, 2'd1, 1'b0, 1'b0, 2'd2},
    '{22'h000123, 22'h000456, 12'd4,   12'd4,   12'd0, 12'd0, 2'd0, 1'b0, 1'b0, 2'd1},
    '{22'h3FFFFE, 22'h000002, 12'd4095,12'd10,  12'd2, 12'd1, 2'd1, 1'b1, 1'b1, 2'd3}
  };

  logic        clk, rst_n, start, rev_x, rev_y, busy, out_valid, out_ready;
  logic [21:0] src_base, dst_base, src_addr, dst_addr;
  logic [11:0] src_pitch, dst_pitch, width_m1, height_m1;
  logic [1:0]  pix_fmt, draw_mode;

  int n_chk, n_fail;
  bit done;

  blit_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_base(src_base), .dst_base(dst_base),
    .src_pitch(src_pitch), .dst_pitch(dst_pitch),
    .width_m1(width_m1), .height_m1(height_m1),
    .pix_fmt(pix_fmt), .rev_x(rev_x), .rev_y(rev_y), .draw_mode(draw_mode),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [21:0] model_addr(input logic [21:0] base, input logic [11:0] pitch,
                                             input int bpp, input int r, input int c,
                                             input logic xn, input logic yn);
    int roff, coff;
    roff = int'(pitch) * r;
    coff = bpp * c;
    if (yn) roff = -roff;
    if (xn) coff = -coff;
    return 22'(int'(base) + roff + coff);
  endfunction

  task automatic apply_cfg(input vec_t v);
    src_base  = v.src;  dst_base  = v.dst;
    src_pitch = v.sp;   dst_pitch = v.dp;
    width_m1  = v.w;    height_m1 = v.h;
    pix_fmt   = v.fmt;  rev_x     = v.xn;
    rev_y     = v.yn;   draw_mode = v.mode;
  endtask

  // stall: drop ready on a pattern; poke: strobe start with new inputs mid-walk
  task automatic run_vec(input vec_t v, input bit stall, input bit poke, input string tag);
    logic [21:0] es [64];
    logic [21:0] ed [64];
    int nexp, npos, idx, got, busy_cyc, stalls, cyc, bpp;
    bit  pend;
    logic [21:0] ps, pd;
    nexp = 0;
    npos = (int'(v.w) + 1) * (int'(v.h) + 1);
    bpp  = int'(v.fmt) + 1;
    idx  = 0;
    for (int r = 0; r <= int'(v.h); r++) begin
      for (int c = 0; c <= int'(v.w); c++) begin
        // R7: mode 1 drops the first position, mode 2 the last
        if (!((v.mode == 2'd1 && idx == 0) || (v.mode == 2'd2 && idx == npos - 1))) begin
          es[nexp] = model_addr(v.src, v.sp, bpp, r, c, v.xn, v.yn);
          ed[nexp] = model_addr(v.dst, v.dp, bpp, r, c, v.xn, v.yn);
          nexp++;
        end
        idx++;
      end
    end
    @(negedge clk);
    check(busy == 1'b0, "R1", {tag, " idle before start"}, 32'(busy), 0);
    apply_cfg(v);
    start = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", {tag, " busy after start"}, 32'(busy), 1);
    got = 0; busy_cyc = 0; stalls = 0; cyc = 0; pend = 1'b0; ps = '0; pd = '0;
    while (busy && cyc < 300) begin
      if (pend) begin
        check(out_valid && src_addr == ps && dst_addr == pd, "R6", {tag, " stalled pair held"},
              32'(src_addr), 32'(ps));
      end
      busy_cyc++;
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      if (poke && cyc == 1) begin
        start = 1'b1;
        src_base = 22'h155555; dst_base = 22'h2AAAAA; pix_fmt = ~v.fmt; rev_x = ~v.xn;
      end else if (poke && cyc == 2) begin
        start = 1'b0;
      end
      if (out_valid) begin
        if (!out_ready) begin
          stalls++;
          pend = 1'b1; ps = src_addr; pd = dst_addr;
        end else begin
          pend = 1'b0;
          if (got < nexp) begin
            // R3 R4 R5: pair order and values from the position model
            check(src_addr == es[got], poke ? "R9" : "R4", {tag, " src address"},
                  32'(src_addr), 32'(es[got]));
            check(dst_addr == ed[got], "R5", {tag, " dst address"},
                  32'(dst_addr), 32'(ed[got]));
          end
          got++;
        end
      end else begin
        pend = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b1;
    check(got == nexp, "R7", {tag, " emitted pair count"}, 32'(got), 32'(nexp));
    check(busy_cyc == npos + stalls, "R8", {tag, " busy length"}, 32'(busy_cyc),
          32'(npos + stalls));
    check(out_valid == 1'b0, "R1", {tag, " quiet when idle"}, 32'(out_valid), 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b1;
    apply_cfg(VECS[0]);
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0, "R1", "in reset", {30'd0, busy, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0, "R1", "after reset", {30'd0, busy, out_valid}, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 1'b0, 1'b0, $sformatf("vec%0d", i));

    // corner cases
    run_vec(VECS[0], 1'b1, 1'b0, "stall_rows");
    run_vec(VECS[4], 1'b1, 1'b0, "stall_drop_head");
    run_vec(VECS[3], 1'b0, 1'b1, "start_while_busy_r9");
    run_vec(VECS[5], 1'b1, 1'b1, "poke_stall_tail");

    // reset in the middle of a walk
    @(negedge clk);
    apply_cfg(VECS[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy == 1'b0 && out_valid == 1'b0, "R1", "reset mid-walk", {30'd0, busy, out_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_vec(VECS[2], 1'b0, 1'b0, "after_reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule